// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a serial stereo PCM stream into parallel left and right samples. Three lines carry the stream: a shift clock, a frame clock whose level marks the channel, and a data line. All three are treated as synchronous inputs and sampled with the system clock. A rising edge of the shift clock is found by comparing the present level with the level seen one system clock earlier. The data line is captured at each such edge.

A 7-bit configuration word picks one of thirteen framings. A compact mode carries 16-bit words in 16 shift clocks per half-frame. The wide modes use 32 shift clocks per half-frame (64 per frame) and place 16, 18, 20 or 24-bit words left-justified, right-justified or in I2S position. Every received word comes out sign-extended to 24 bits, together with a one-cycle strobe for its channel.

The output has no ready signal and no back-pressure. Audio arrives at a fixed rate, so the consumer must take each word in the cycle its strobe is high. The sample register then holds that word until the next strobe for the same channel.

Top module: `audio_serial_rx`

## Requirements
- R1: Configuration word layout: bit 6 selects wide (1) or compact (0) mode, bits 5:4 give the framing, bits 3:2 are ignored, bits 1:0 give the word length. The word is latched at the shift-clock rising edge where the frame clock is first seen at a new level. A change between such edges has no effect until the next one.
- R2: Framing 00 (left-justified, wide): the MSB is the bit at the first shift-clock rising edge after a frame-clock change, positions 0..N-1. The frame clock high marks the left channel.
- R3: Framing 10 (I2S, wide): the MSB is at position 1, so bits occupy positions 1..N. The frame clock low marks the left channel.
- R4: Framing 01 (right-justified, wide): the word occupies the last N of the 32 positions of the half-frame, positions 32-N..31. The frame clock high marks the left channel.
- R5: Compact mode (bit 6 = 0): each half-frame has 16 positions, and the word is 16 bits at positions 0..15. The frame clock high marks the left channel. Bits 5:4 and 1:0 are ignored.
- R6: Word-length codes in wide mode: 00 = 16, 01 = 18, 10 = 20, 11 = 24 bits.
- R7: Words are received MSB first and output sign-extended to 24 bits.
- R8: Exactly one strobe, left or right and never both, goes high for one system clock. It comes in the cycle after the shift-clock edge that carried the last bit of a word. A sample output changes only with its strobe.
- R9: Framing 11 in wide mode produces no strobe and leaves both sample outputs unchanged.
- R10: After reset, both samples read zero and no strobe occurs before the first frame-clock change.
- R11: Data and the frame clock are sampled on shift-clock rising edges. Each shift-clock level must last at least one system clock, and the shift clock is low when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_i | input | 1 | Shift clock, sampled by clk |
| lrck_i | input | 1 | Frame clock, channel select |
| sdin_i | input | 1 | Serial data |
| cfg_word_i | input | 7 | Format selection word (R1 layout) |
| left_o | output | 24 | Last left sample, sign-extended |
| right_o | output | 24 | Last right sample, sign-extended |
| left_vld_o | output | 1 | One-cycle strobe for a new left sample |
| right_vld_o | output | 1 | One-cycle strobe for a new right sample |

## Verification
A wrong bit position inside the half-frame shows up one system clock after the last bit of the word. Depending on the fault, the strobe is missing or comes at the wrong time, or the word is shifted by one or more bits. A wrong latched configuration or a wrong channel decision shows up in the next half-frame: the word lands in the wrong channel, or the sign extension is cut at the wrong width. The bench compares strobes and both samples every system clock against a behavioural model, so any such error is reported in the cycle it first reaches a port.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

  typedef enum logic [1:0] {
    FMT_LEFT  = 2'b00,
    FMT_RIGHT = 2'b01,
    FMT_I2S   = 2'b10,
    FMT_NONE  = 2'b11
  } frame_fmt_e;

  // Bit layout follows the configuration word: [6] wide, [5:4] framing,
  // [3:2] reserved, [1:0] word length.
  typedef struct packed {
    logic       wide;
    frame_fmt_e fmt;
    logic [1:0] rsvd;
    logic [1:0] wl;
  } rx_cfg_t;

  function automatic int unsigned wl_bits(input logic [1:0] wl);
    case (wl)
      2'b00:   return 16;
      2'b01:   return 18;
      2'b10:   return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/asrx_edge.sv
module asrx_edge #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck,
  input  logic             lrck,
  output logic             bit_stb,
  output logic             lr_chg,
  output logic [CNT_W-1:0] pos
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sck_q;
  logic             lr_q;
  logic [CNT_W-1:0] cnt_q;

  assign bit_stb = sck & ~sck_q;
  assign lr_chg  = bit_stb & (lrck != lr_q);
  // Position of the bit arriving at this edge within its half-frame;
  // saturates so nothing is taken before the first frame-clock change.
  assign pos = lr_chg ? '0 : ((cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      lr_q  <= 1'b0;
      cnt_q <= CNT_MAX;
    end else begin
      sck_q <= sck;
      if (bit_stb) begin
        lr_q  <= lrck;
        cnt_q <= pos;
      end
    end
  end
endmodule

// File: rtl/asrx_window.sv
module asrx_window
  import asrx_pkg::*;
#(
  parameter int CNT_W       = 6,
  parameter int HALF_WIDE   = 32,
  parameter int HALF_NARROW = 16
) (
  input  logic             wide,
  input  frame_fmt_e       fmt,
  input  logic [1:0]       wl,
  input  logic [CNT_W-1:0] pos,
  input  logic             lr,
  output logic             take,
  output logic             last,
  output logic             to_left,
  output logic [CNT_W-1:0] nbits
);
  localparam logic [CNT_W-1:0] HW = CNT_W'(HALF_WIDE);
  localparam logic [CNT_W-1:0] HN = CNT_W'(HALF_NARROW);

  logic [CNT_W-1:0] first_p;
  logic [CNT_W-1:0] last_p;
  logic             usable;

  always_comb begin
    nbits   = HN;
    first_p = '0;
    usable  = 1'b1;
    to_left = lr;
    if (wide) begin
      nbits = CNT_W'(wl_bits(wl));
      case (fmt)
        FMT_LEFT:  first_p = '0;
        FMT_I2S: begin
          first_p = CNT_W'(1);
          to_left = ~lr;
        end
        FMT_RIGHT: first_p = HW - nbits;
        default:   usable = 1'b0;
      endcase
    end
    last_p = first_p + nbits - 1'b1;
    take   = usable && (pos >= first_p) && (pos <= last_p);
    last   = usable && (pos == last_p);
  end
endmodule

// File: rtl/asrx_shift.sv
module asrx_shift #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                last,
  input  logic                to_left,
  input  logic [CNT_W-1:0]    nbits,
  input  logic                sdin,
  output logic [SAMPLE_W-1:0] left,
  output logic [SAMPLE_W-1:0] right,
  output logic                left_vld,
  output logic                right_vld
);
  logic [SAMPLE_W-1:0] sh;
  logic [SAMPLE_W-1:0] word;
  logic [SAMPLE_W-1:0] aligned;
  logic [SAMPLE_W-1:0] extended;
  logic [CNT_W-1:0]    pad;

  assign word     = {sh[SAMPLE_W-2:0], sdin};
  assign pad      = CNT_W'(SAMPLE_W) - nbits;
  assign aligned  = word << pad;
  assign extended = SAMPLE_W'($signed(aligned) >>> pad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '0;
      left      <= '0;
      right     <= '0;
      left_vld  <= 1'b0;
      right_vld <= 1'b0;
    end else begin
      left_vld  <= 1'b0;
      right_vld <= 1'b0;
      if (take) sh <= word;
      if (last) begin
        if (to_left) begin
          left     <= extended;
          left_vld <= 1'b1;
        end else begin
          right     <= extended;
          right_vld <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import asrx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int FRAME_WIDE  = 64,
  parameter int FRAME_SMALL = 32,
  parameter int CNT_W       = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_i,
  input  logic                lrck_i,
  input  logic                sdin_i,
  input  logic [6:0]          cfg_word_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                left_vld_o,
  output logic                right_vld_o
);
  localparam int HALF_WIDE   = FRAME_WIDE / 2;
  localparam int HALF_NARROW = FRAME_SMALL / 2;

  logic             bit_stb;
  logic             lr_chg;
  logic [CNT_W-1:0] pos;
  logic             take;
  logic             last;
  logic             to_left;
  logic [CNT_W-1:0] nbits;
  rx_cfg_t          cfg_q;
  rx_cfg_t          cfg_eff;

  asrx_edge #(.CNT_W(CNT_W)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck     (sck_i),
    .lrck    (lrck_i),
    .bit_stb (bit_stb),
    .lr_chg  (lr_chg),
    .pos     (pos)
  );

  // The configuration in force for a half-frame is the one seen at its first edge.
  assign cfg_eff = lr_chg ? rx_cfg_t'(cfg_word_i) : cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (lr_chg) cfg_q <= cfg_eff;
  end

  asrx_window #(
    .CNT_W       (CNT_W),
    .HALF_WIDE   (HALF_WIDE),
    .HALF_NARROW (HALF_NARROW)
  ) u_window (
    .wide    (cfg_eff.wide),
    .fmt     (cfg_eff.fmt),
    .wl      (cfg_eff.wl),
    .pos     (pos),
    .lr      (lrck_i),
    .take    (take),
    .last    (last),
    .to_left (to_left),
    .nbits   (nbits)
  );

  asrx_shift #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (bit_stb & take),
    .last      (bit_stb & last),
    .to_left   (to_left),
    .nbits     (nbits),
    .sdin      (sdin_i),
    .left      (left_o),
    .right     (right_o),
    .left_vld  (left_vld_o),
    .right_vld (right_vld_o)
  );
endmodule

// File: rtl/asrx_chk.sv
module asrx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sck_i,
  input logic [6:0]  cfg_q,
  input logic [23:0] left_o,
  input logic [23:0] right_o,
  input logic        left_vld_o,
  input logic        right_vld_o
);
  a_r8_one_side: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_vld_o && right_vld_o));

  a_r8_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !left_vld_o |-> $stable(left_o));

  a_r8_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !right_vld_o |-> $stable(right_o));

  a_r11_strobe_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (left_vld_o || right_vld_o) |-> $past(sck_i));

  a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (left_vld_o || right_vld_o) |-> !(cfg_q[6] && (cfg_q[5:4] == 2'b11)));

  a_r1_cfg_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(sck_i));
endmodule

bind audio_serial_rx asrx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sck_i       (sck_i),
  .cfg_q       (cfg_q),
  .left_o      (left_o),
  .right_o     (right_o),
  .left_vld_o  (left_vld_o),
  .right_vld_o (right_vld_o)
);

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        lrck = 1'b0;
  logic        sdin = 1'b0;
  logic [6:0]  cfg = 7'd0;
  logic [23:0] left_o, right_o;
  logic        left_vld_o, right_vld_o;

  int checks = 0;
  int errors = 0;
  int cnt_l = 0;
  int cnt_r = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  audio_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .lrck_i(lrck), .sdin_i(sdin),
    .cfg_word_i(cfg), .left_o(left_o), .right_o(right_o),
    .left_vld_o(left_vld_o), .right_vld_o(right_vld_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Position rules taken from the requirements (R2..R6, R9)
  function automatic void layout(input logic [6:0] c, output int n, output int s,
                                 output int h, output bit ok, output logic lefthigh);
    ok = 1; s = 0; lefthigh = 1'b1;
    if (!c[6]) begin n = 16; h = 16; end
    else begin
      h = 32;
      n = (c[1:0] == 2'b00) ? 16 : (c[1:0] == 2'b01) ? 18 : (c[1:0] == 2'b10) ? 20 : 24;
      case (c[5:4])
        2'b00: s = 0;
        2'b01: s = 32 - n;
        2'b10: begin s = 1; lefthigh = 1'b0; end
        default: ok = 0;
      endcase
    end
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] w, input int n);
    logic [23:0] mask = (24'd1 << n) - 24'd1;
    logic [23:0] r = w & mask;
    if (w[n-1]) r = r | ~mask;
    return r;
  endfunction

  function automatic string tag(input logic [6:0] c);
    if (!c[6]) return "R5";
    case (c[5:4])
      2'b00: return "R2";
      2'b01: return "R4";
      2'b10: return "R3";
      default: return "R9";
    endcase
  endfunction

  // Behavioural reference model, advanced on every clock
  logic        m_sck_q, m_lr, m_started;
  logic [6:0]  m_cfg;
  bit          q[$];
  logic        e_vl, e_vr;
  logic [23:0] e_left, e_right;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sck_q = 0; m_lr = 0; m_started = 0; m_cfg = 0; q.delete();
      e_vl = 0; e_vr = 0; e_left = 0; e_right = 0;
    end else begin
      e_vl = 0; e_vr = 0;
      if (sck && !m_sck_q) begin
        if (lrck != m_lr) begin
          m_lr = lrck; m_started = 1; q.delete(); m_cfg = cfg;
        end
        if (m_started) begin
          int n, s, h;
          bit ok;
          logic lh;
          logic [23:0] w;
          q.push_back(sdin);
          layout(m_cfg, n, s, h, ok, lh);
          if (ok && q.size() == s + n) begin
            w = 0;
            for (int i = 0; i < n; i++) w = {w[22:0], q[s+i]};
            w = sx(w, n);
            if (m_lr == lh) begin e_vl = 1; e_left = w; end
            else begin e_vr = 1; e_right = w; end
          end
        end
      end
      m_sck_q = sck;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check({left_vld_o, right_vld_o, left_o, right_o} == {e_vl, e_vr, e_left, e_right},
            (left_vld_o != e_vl || right_vld_o != e_vr) ? "R8" : tag(m_cfg),
            "per-clock model compare",
            {14'd0, left_vld_o, right_vld_o, left_o, right_o},
            {14'd0, e_vl, e_vr, e_left, e_right});
      if (left_vld_o)  cnt_l++;
      if (right_vld_o) cnt_r++;
    end
  end

  task automatic sck_bit(input logic d);
    sdin = d; sck = 1'b0;
    repeat (2) @(negedge clk);
    sck = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // One half-frame; optional configuration change after bit chg_at
  task automatic half(input logic [6:0] c, input logic [23:0] word,
                      input int chg_at, input logic [6:0] chg_val, input string req);
    int n, s, h;
    bit ok;
    logic lh;
    logic [23:0] before_l, before_r;
    logic lv;
    layout(c, n, s, h, ok, lh);
    before_l = left_o; before_r = right_o;
    lv = ~lrck;
    lrck = lv;
    for (int b = 0; b < h; b++) begin
      if (b >= s && b < s + n) sck_bit(word[n-1-(b-s)]);
      else sck_bit(1'($urandom));
      if (b == chg_at) cfg = chg_val;
    end
    if (!ok) begin
      check(left_o == before_l && right_o == before_r, "R9", "reserved framing holds outputs",
            {16'd0, left_o, right_o}, {16'd0, before_l, before_r});
    end else if (lv == lh) begin
      check(left_o == sx(word, n), req, "left word", {40'd0, left_o}, {40'd0, sx(word, n)});
    end else begin
      check(right_o == sx(word, n), req, "right word", {40'd0, right_o}, {40'd0, sx(word, n)});
    end
  endtask

  task automatic run_mode(input logic [6:0] c, input int frames, input string req);
    int exp_cnt;
    cfg = c;
    cnt_l = 0; cnt_r = 0;
    for (int f = 0; f < frames; f++) begin
      half(c, 24'($urandom), -1, c, req);
      half(c, 24'($urandom), -1, c, req);
    end
    exp_cnt = (c[6] && c[5:4] == 2'b11) ? 0 : frames;
    check(cnt_l == exp_cnt && cnt_r == exp_cnt, (exp_cnt == 0) ? "R9" : "R6",
          "strobe count per channel", {32'(cnt_l), 32'(cnt_r)},
          {32'(exp_cnt), 32'(exp_cnt)});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(left_o == 0 && right_o == 0 && !left_vld_o && !right_vld_o, "R10",
          "reset state", {14'd0, left_vld_o, right_vld_o, left_o, right_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cnt_l = 0; cnt_r = 0;
    cfg = 7'b1_00_00_11;
    for (int i = 0; i < 40; i++) sck_bit(1'($urandom));
    check(cnt_l == 0 && cnt_r == 0 && left_o == 0, "R10", "no strobe before first frame-clock change",
          {32'(cnt_l), 32'(cnt_r)}, 64'd0);

    // Compact mode with the ignored fields set to non-zero values (R5, R11)
    run_mode(7'b0_10_00_11, 3, "R5");
    // Sign extension, directed extremes in wide left-justified 24-bit (R7)
    cfg = 7'b1_00_00_11;
    half(cfg, 24'h800001, -1, cfg, "R7");
    half(cfg, 24'h7FFFFE, -1, cfg, "R7");
    // Reserved bits 3:2 set: must not matter (R1)
    run_mode(7'b1_00_11_01, 2, "R1");
    for (int f = 0; f < 3; f++) begin
      for (int w = 0; w < 4; w++) begin
        logic [6:0] c;
        c = {1'b1, 2'(f), 2'b00, 2'(w)};
        run_mode(c, 3, tag(c));
      end
    end
    // Reserved framing: no strobes (R9)
    run_mode(7'b1_11_00_10, 2, "R9");
    // Mid-half configuration change takes effect at the next transition (R1)
    cfg = 7'b1_00_00_00;
    half(cfg, 24'h00A5C3, 4, 7'b1_10_00_11, "R1");
    half(7'b1_10_00_11, 24'hC0FFEE, -1, 7'b1_10_00_11, "R1");
    // Negative 18-bit right-justified word (R7, R4)
    cfg = 7'b1_01_00_01;
    half(cfg, 24'h020001, -1, cfg, "R7");
    half(cfg, 24'h01FFFF, -1, cfg, "R4");
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule